// File: doc/BRIEF.md
# Serial Audio FIFO Pair with Debug Freeze

This block sits between a word-wide register bus and a one-bit serial audio link. Samples that arrive on the serial input are gathered into words and queued in a receive FIFO, which the bus reads. Words that the bus writes are queued in a transmit FIFO and moved into a shift register at each word boundary, then sent out one bit at a time. Both directions share one bit counter, driven by a bit-clock enable, so a word boundary is the same cycle for receive and transmit.

Each FIFO reports its fill state through registered flags. A sticky error flag in each direction records a lost word (receive) or a missing word (transmit), and the bus clears it with a write-one pulse.

A debug freeze input lets an external debugger look at the block without changing it. The freeze request comes from another clock domain and is resynchronized. While the synchronized freeze is high, no FIFO content, pointer, status flag or transmit load changes, although the bus may keep reading and writing and the serial side keeps clocking.

Top module: `audio_fifo_frz`

## Requirements
- R1: After reset both FIFOs hold no words, `rx_empty`, `tx_empty` and `tx_aempty` are 1, `rx_full`, `rx_afull`, `tx_full`, `rx_ovr`, `tx_und` and `frozen` are 0, and `sdout` is 0.
- R2: Every 16 cycles with `bit_en` high form one received word. Bits are taken from `sdin` MSB first, and the finished word is appended to the receive FIFO. `rx_rdata` shows the oldest word (0 when empty), and a `rx_rd` pulse removes it, so words leave in arrival order.
- R3: The receive flags follow the number of stored words N (capacity 8). `rx_empty` is N==0, `rx_full` is N==8 and `rx_afull` is N>=6. They update on the same edge as the push or pop.
- R4: A received word that completes while the receive FIFO is full is dropped, and `rx_ovr` becomes 1 on that edge. The flag stays 1 until a `ovr_clr` pulse clears it.
- R5: A `tx_wr` pulse appends `tx_wdata` to the transmit FIFO. At each word boundary (the 16th `bit_en` cycle) the oldest word is loaded into the shift register, and during the next word period it appears on `sdout` MSB first.
- R6: The transmit flags follow the stored count N. `tx_empty` is N==0, `tx_full` is N==8 and `tx_aempty` is N<=2. A write while full is discarded and never transmitted.
- R7: A word boundary that finds the transmit FIFO empty loads zeros, so the next word period sends 0. It also sets `tx_und`, which stays 1 until a `und_clr` pulse clears it.
- R8: `frozen` goes high on the second rising clock edge after `frz_in` rises, and goes low on the second edge after it falls.
- R9: While `frozen` is 1, a completed serial word is not stored, and `rx_rd` leaves the head word in place. `rx_empty`, `rx_full`, `rx_afull` and `rx_ovr` keep their values, including against `ovr_clr`.
- R10: While `frozen` is 1, `tx_wr` is discarded, and a word boundary does not load the shift register, so the following word period sends 0. `tx_empty`, `tx_full`, `tx_aempty` and `tx_und` keep their values, including against `und_clr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Audio-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| frz_in | input | 1 | Debug freeze request, asynchronous to clk |
| frozen | output | 1 | Synchronized freeze in effect |
| bit_en | input | 1 | One serial bit per cycle when high |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| rx_rd | input | 1 | Pop the receive head word |
| rx_rdata | output | 16 | Receive head word, 0 when empty |
| tx_wr | input | 1 | Push `tx_wdata` into the transmit FIFO |
| tx_wdata | input | 16 | Transmit word from the bus |
| ovr_clr | input | 1 | Write-one clear of `rx_ovr` |
| und_clr | input | 1 | Write-one clear of `tx_und` |
| rx_ovr | output | 1 | Sticky receive overrun |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_afull | output | 1 | Receive FIFO at 6 or more words |
| tx_und | output | 1 | Sticky transmit underrun |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_aempty | output | 1 | Transmit FIFO at 2 or fewer words |

## Verification
The assertions assume that `bit_en` runs in complete 16-cycle words from reset, so that the shared bit counter and the bench agree on where a word boundary falls. They also assume that `frz_in` changes only between clock edges, so that the synchronizer sees a clean level. The stimulus always sends whole words through one task, which holds `bit_en` high for exactly 16 cycles. It changes `frz_in` at falling edges and waits two rising edges before it relies on the new freeze state. The hold checks under freeze therefore always start from a known, settled `frozen` level.

// File: rtl/afz_pkg.sv
package afz_pkg;
  localparam int unsigned AFZ_WORD_W  = 16;
  localparam int unsigned AFZ_DEPTH   = 8;
  localparam int unsigned AFZ_HI_LVL  = 6;
  localparam int unsigned AFZ_LO_LVL  = 2;
  localparam int unsigned AFZ_SYNC_N  = 2;

  // fill-state view of one queue
  typedef struct packed {
    logic empty;
    logic full;
    logic hi;
    logic lo;
  } afz_fill_t;
endpackage

// File: rtl/afz_sync.sv
module afz_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/afz_fifo.sv
module afz_fifo
  import afz_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned HI_LVL = 6,
  parameter int unsigned LO_LVL = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output afz_fill_t    fill
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && !fill.full;
  assign do_pop  = pop && !fill.empty;
  assign cnt_nxt = cnt + CW'(do_push) - CW'(do_pop);

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      fill <= '{empty: 1'b1, full: 1'b0, hi: 1'b0, lo: 1'b1};
    end else begin
      if (do_push) wptr <= ptr_inc(wptr);
      if (do_pop)  rptr <= ptr_inc(rptr);
      cnt        <= cnt_nxt;
      fill.empty <= (cnt_nxt == '0);
      fill.full  <= (cnt_nxt == CW'(DEPTH));
      fill.hi    <= (cnt_nxt >= CW'(HI_LVL));
      fill.lo    <= (cnt_nxt <= CW'(LO_LVL));
    end
  end

  assign head = mem[rptr];

  // R3 R6
  fifo_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R3 R6
  full_stays_chk: assert property (@(posedge clk) disable iff (rst)
    fill.full && push && !pop |=> fill.full && $stable(wptr));
endmodule

// File: rtl/afz_serial.sv
module afz_serial #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_en,
  input  logic         sdin,
  input  logic         hold,
  input  logic [W-1:0] load_word,
  output logic         word_done,
  output logic [W-1:0] rx_word,
  output logic         sdout
);
  localparam int unsigned BW = $clog2(W);

  logic [BW-1:0] bit_cnt;
  logic [W-1:0]  rsr, tsr;

  assign word_done = bit_en && (bit_cnt == BW'(W - 1));
  assign rx_word   = {rsr[W-2:0], sdin};
  assign sdout     = tsr[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      rsr     <= '0;
      tsr     <= '0;
    end else if (bit_en) begin
      bit_cnt <= word_done ? '0 : bit_cnt + 1'b1;
      rsr     <= rx_word;
      if (word_done && !hold) tsr <= load_word;
      else                    tsr <= {tsr[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/audio_fifo_frz.sv
module audio_fifo_frz
  import afz_pkg::*;
#(
  parameter int unsigned WORD_W = AFZ_WORD_W,
  parameter int unsigned DEPTH  = AFZ_DEPTH,
  parameter int unsigned HI_LVL = AFZ_HI_LVL,
  parameter int unsigned LO_LVL = AFZ_LO_LVL,
  parameter int unsigned SYNC_N = AFZ_SYNC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frz_in,
  output logic              frozen,
  input  logic              bit_en,
  input  logic              sdin,
  output logic              sdout,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_rdata,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_wdata,
  input  logic              ovr_clr,
  input  logic              und_clr,
  output logic              rx_ovr,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              rx_afull,
  output logic              tx_und,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_aempty
);
  logic              frz_q;
  logic              word_done;
  logic [WORD_W-1:0] rx_word, rx_head, tx_head, tx_load;
  afz_fill_t         rx_fill, tx_fill;

  afz_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(frz_in), .q(frz_q)
  );

  afz_serial #(.W(WORD_W)) u_serial (
    .clk(clk), .rst(rst), .bit_en(bit_en), .sdin(sdin), .hold(frz_q),
    .load_word(tx_load), .word_done(word_done), .rx_word(rx_word),
    .sdout(sdout)
  );

  afz_fifo #(.W(WORD_W), .DEPTH(DEPTH), .HI_LVL(HI_LVL), .LO_LVL(LO_LVL)) u_rxq (
    .clk(clk), .rst(rst),
    .push(word_done && !frz_q), .wdata(rx_word),
    .pop(rx_rd && !frz_q), .head(rx_head), .fill(rx_fill)
  );

  afz_fifo #(.W(WORD_W), .DEPTH(DEPTH), .HI_LVL(HI_LVL), .LO_LVL(LO_LVL)) u_txq (
    .clk(clk), .rst(rst),
    .push(tx_wr && !frz_q), .wdata(tx_wdata),
    .pop(word_done && !frz_q), .head(tx_head), .fill(tx_fill)
  );

  assign tx_load  = tx_fill.empty ? '0 : tx_head;
  assign rx_rdata = rx_fill.empty ? '0 : rx_head;

  // sticky error flags, frozen together with the queues
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ovr <= 1'b0;
      tx_und <= 1'b0;
    end else if (!frz_q) begin
      if (word_done && rx_fill.full) rx_ovr <= 1'b1;
      else if (ovr_clr)              rx_ovr <= 1'b0;
      if (word_done && tx_fill.empty) tx_und <= 1'b1;
      else if (und_clr)               tx_und <= 1'b0;
    end
  end

  assign frozen    = frz_q;
  assign rx_empty  = rx_fill.empty;
  assign rx_full   = rx_fill.full;
  assign rx_afull  = rx_fill.hi;
  assign tx_full   = tx_fill.full;
  assign tx_empty  = tx_fill.empty;
  assign tx_aempty = tx_fill.lo;

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    frz_q |=> $stable({rx_ovr, rx_empty, rx_full, rx_afull}));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    frz_q |=> $stable({tx_und, tx_empty, tx_full, tx_aempty}));

  // R4
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ovr && !ovr_clr |=> rx_ovr);

  // R7
  und_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tx_und && !und_clr |=> tx_und);

  // R7
  und_zero_chk: assert property (@(posedge clk) disable iff (rst)
    word_done && !frz_q && tx_empty |=> !sdout && tx_und);
endmodule

// File: tb/test_audio_fifo_frz.sv
module test_audio_fifo_frz;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frz_in = 1'b0, bit_en = 1'b0, sdin = 1'b0;
  logic        rx_rd = 1'b0, tx_wr = 1'b0, ovr_clr = 1'b0, und_clr = 1'b0;
  logic [15:0] tx_wdata = '0;
  logic [15:0] rx_rdata;
  logic        frozen, sdout, rx_ovr, rx_empty, rx_full, rx_afull;
  logic        tx_und, tx_full, tx_empty, tx_aempty;
  int          n_vec = 0, n_bad = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  audio_fifo_frz i_audio_fifo_frz (
    .clk(clk), .rst(rst), .frz_in(frz_in), .frozen(frozen),
    .bit_en(bit_en), .sdin(sdin), .sdout(sdout),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .ovr_clr(ovr_clr), .und_clr(und_clr),
    .rx_ovr(rx_ovr), .rx_empty(rx_empty), .rx_full(rx_full), .rx_afull(rx_afull),
    .tx_und(tx_und), .tx_full(tx_full), .tx_empty(tx_empty), .tx_aempty(tx_aempty)
  );

  // rx word in [31:16], tx word in [15:0]
  localparam logic [31:0] VEC [6] = '{
    32'hA5C3_1234, 32'h0001_8000, 32'hFFFF_0000,
    32'h8000_7FFE, 32'h1357_FFFF, 32'hC0DE_9ABC
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] d);
    @(negedge clk); tx_wdata = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic bus_read(output logic [15:0] d);
    @(negedge clk); d = rx_rdata; rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic pulse_ovr_clr();
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
  endtask

  task automatic pulse_und_clr();
    @(negedge clk); und_clr = 1'b1;
    @(negedge clk); und_clr = 1'b0;
  endtask

  task automatic set_freeze(input logic v);
    @(negedge clk); frz_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w, output logic [15:0] got);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      got[15-i] = sdout;
      sdin = w[15-i];
      bit_en = 1'b1;
    end
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] got, rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", {7'b0, rx_empty, rx_full, rx_afull, rx_ovr, tx_empty, tx_full, tx_aempty, tx_und, frozen},
        16'b0000000_1_0_0_0_1_0_1_0_0);
    chk("R1 sdout", {15'b0, sdout}, 16'h0);

    // table walk: R2 receive order, R5 transmit one word behind
    for (int i = 0; i < 6; i++) begin
      bus_write(VEC[i][15:0]);
      send_word(VEC[i][31:16], got);
      chk("R5 tx word", got, (i == 0) ? 16'h0 : VEC[i-1][15:0]);
      bus_read(rd);
      chk("R2 rx word", rd, VEC[i][31:16]);
    end

    // R7 underrun: boundary with empty transmit queue
    send_word(16'h0F0F, got);
    chk("R5 last tx", got, VEC[5][15:0]);
    chk("R7 und set", {15'b0, tx_und}, 16'h1);
    send_word(16'h0F10, got);
    chk("R7 zero out", got, 16'h0);
    bus_read(rd); bus_read(rd);
    chk("R2 rx after", rd, 16'h0F10);
    pulse_und_clr();
    chk("R7 und clr", {15'b0, tx_und}, 16'h0);

    // R3 receive fill flags, R4 overrun
    for (int k = 0; k < 8; k++) begin
      send_word(16'h1000 + 16'(k), got);
      if (k == 4) chk("R3 afull at 5", {15'b0, rx_afull}, 16'h0);
      if (k == 5) chk("R3 afull at 6", {15'b0, rx_afull}, 16'h1);
      if (k == 6) chk("R3 not full 7", {15'b0, rx_full}, 16'h0);
    end
    chk("R3 full at 8", {15'b0, rx_full}, 16'h1);
    chk("R4 no ovr yet", {15'b0, rx_ovr}, 16'h0);
    send_word(16'hDEAD, got);
    chk("R4 ovr set", {15'b0, rx_ovr}, 16'h1);
    set_freeze(1'b1);
    pulse_ovr_clr();
    chk("R9 ovr held", {15'b0, rx_ovr}, 16'h1);
    set_freeze(1'b0);
    chk("R4 ovr sticky", {15'b0, rx_ovr}, 16'h1);
    pulse_ovr_clr();
    chk("R4 ovr clr", {15'b0, rx_ovr}, 16'h0);
    for (int k = 0; k < 8; k++) begin
      bus_read(rd);
      chk("R4 kept words", rd, 16'h1000 + 16'(k));
    end
    chk("R3 empty", {15'b0, rx_empty}, 16'h1);
    pulse_und_clr();

    // R6 transmit fill flags and discarded write
    for (int k = 0; k < 8; k++) begin
      bus_write(16'h2000 + 16'(k));
      if (k == 1) chk("R6 aempty at 2", {15'b0, tx_aempty}, 16'h1);
      if (k == 2) chk("R6 aempty at 3", {15'b0, tx_aempty}, 16'h0);
    end
    chk("R6 full", {15'b0, tx_full}, 16'h1);
    bus_write(16'hBEEF);
    for (int k = 0; k < 10; k++) begin
      send_word(16'h0000, got);
      if (k >= 1 && k <= 8) chk("R6 tx order", got, 16'h2000 + 16'(k - 1));
      if (k == 9) chk("R6 full write dropped", got, 16'h0);
      bus_read(rd);
    end
    pulse_und_clr();

    // freeze behaviour
    bus_write(16'h3C3C);
    send_word(16'h4001, got);
    chk("R7 zero before load", got, 16'h0);
    bus_write(16'h5A5A);
    @(negedge clk); frz_in = 1'b1;
    @(negedge clk);
    chk("R8 one edge", {15'b0, frozen}, 16'h0);
    @(negedge clk);
    chk("R8 two edges", {15'b0, frozen}, 16'h1);
    bus_read(rd);
    chk("R9 head", rd, 16'h4001);
    bus_read(rd);
    chk("R9 no pop", rd, 16'h4001);
    chk("R9 empty held", {15'b0, rx_empty}, 16'h0);
    bus_write(16'hFFFF);
    chk("R10 tx flags held", {13'b0, tx_empty, tx_full, tx_aempty}, 16'b001);
    send_word(16'h4002, got);
    chk("R5 loaded before freeze", got, 16'h3C3C);
    send_word(16'h4003, got);
    chk("R10 no load", got, 16'h0);
    chk("R10 und held", {15'b0, tx_und}, 16'h0);
    @(negedge clk); frz_in = 1'b0;
    @(negedge clk);
    chk("R8 release one edge", {15'b0, frozen}, 16'h1);
    @(negedge clk);
    chk("R8 release two edges", {15'b0, frozen}, 16'h0);
    send_word(16'h4004, got);
    chk("R10 zeros after", got, 16'h0);
    send_word(16'h4005, got);
    chk("R10 resumed load", got, 16'h5A5A);
    chk("R7 und after T3 dropped", {15'b0, tx_und}, 16'h1);
    bus_read(rd); chk("R9 rx order A", rd, 16'h4001);
    bus_read(rd); chk("R9 rx order D", rd, 16'h4004);
    bus_read(rd); chk("R9 rx order E", rd, 16'h4005);
    chk("R9 frozen words dropped", {15'b0, rx_empty}, 16'h1);
    set_freeze(1'b1);
    pulse_und_clr();
    chk("R10 und clr ignored", {15'b0, tx_und}, 16'h1);
    set_freeze(1'b0);
    pulse_und_clr();
    chk("R7 und clr after", {15'b0, tx_und}, 16'h0);

    done = 1'b1;
    finish_run();
  end
endmodule